// File: doc/BRIEF.md
# Radix-4 Carry-Save Significand Divider

This block divides one normalized fixed-point significand by another. It is the iterative core of the significand path in a floating-point divide unit. A request is offered with `start` while `busy` is low. The block then produces one radix-4 quotient digit per clock from the digit set {-2,-1,0,+1,+2}. The partial remainder is kept as a sum word and a carry word, so that no carry chain has to settle inside the loop.

Each digit is chosen without a selection table. A seven-bit estimate of the shifted remainder (three integer bits and four fraction bits) is compared against four thresholds. Those thresholds are derived at start from the three divisor bits below the leading one, and they stand for truncated multiples of the divisor. A small coder turns the comparator outputs into the digit magnitude. The digit sign is taken from the estimate's sign bit on a path of its own. Digits are folded into a binary quotient as they arrive, using a pair of registers that hold Q and Q-1. When the last digit has been retired, one extra cycle adds the two remainder words. If that remainder is negative, the cycle takes Q-1 and adds the divisor back. It then delivers the quotient, the remainder and a sticky flag.

Exponents, rounding and special operands are handled outside this block.

Top module: `srt4_div`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `sticky` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` seen at a rising edge while `busy` is low is accepted, and `busy` is high in the following cycle.
- R3: `done` is high for exactly one cycle. It rises on the ITERS+1-th rising edge after the accepting edge, where ITERS = (QBITS+3)/2, and `busy` is low in that same cycle.
- R4: With both operands having their most significant bit set, `quotient` equals floor(A·4^(ITERS-1) / B), where A is `dividend` and B is `divisor`, both read as unsigned integers.
- R5: `remainder` equals A·4^(ITERS-1) − B·`quotient` and lies in [0, B).
- R6: `sticky` is 1 exactly when the delivered remainder is nonzero.
- R7: A `start` raised while `busy` is high is ignored. The operation already in flight completes with its own operands and its own latency.
- R8: A `start` raised in the cycle in which `done` is high is accepted as a new operation.
- R9: At every iteration, the assimilated partial remainder has a magnitude no larger than the divisor.
- R10: `quotient`, `remainder` and `sticky` hold their values from one `done` until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; taken when `busy` is low |
| dividend | input | W | Dividend significand, MSB set |
| divisor | input | W | Divisor significand, MSB set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 2·ITERS | Binary quotient |
| remainder | output | W | Final non-negative remainder |
| sticky | output | 1 | Remainder is nonzero |

## Verification
Two things can fall in the same cycle: the delivery of a result, shown by `done`, and the acceptance of the next request. The bench therefore raises `start` in the very cycle it sees `done`, across the whole random sweep and in one directed case. It judges the overlap by three observations. The just-delivered result must be correct. `busy` must be high one cycle later. The second result must match its own operands, with the full latency. A second hazard is a stray `start` during the run. This is provoked mid-iteration and judged by the first result remaining that of the first operands.

// File: rtl/srt4_pkg.sv
package srt4_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_FIN
  } srt4_state_e;

  // Selection thresholds in units of 1/16, for one divisor interval.
  typedef struct packed {
    logic signed [7:0] pos1;  // estimate >= pos1 -> magnitude at least 1
    logic signed [7:0] pos2;  // estimate >= pos2 -> magnitude 2
    logic signed [7:0] neg1;  // estimate <= neg1 -> magnitude at least 1
    logic signed [7:0] neg2;  // estimate <= neg2 -> magnitude 2
  } srt4_thr_t;

  // The divisor lies in [(8+i)/16, (9+i)/16). Each threshold is the truncated
  // multiple k*d_hi/3 (k = 1 or 4), with 2 units of estimate error for the
  // negative side.
  function automatic srt4_thr_t srt4_thresholds(input logic [2:0] dtop);
    int hi;
    srt4_thr_t t;
    hi     = 9 + int'(dtop);
    t.pos1 = 8'((hi + 2) / 3);
    t.pos2 = 8'((4 * hi + 2) / 3);
    t.neg1 = 8'(-((hi + 2) / 3) - 2);
    t.neg2 = 8'(-((4 * hi + 2) / 3) - 2);
    return t;
  endfunction

endpackage

// File: rtl/srt4_qds.sv
module srt4_qds
  import srt4_pkg::*;
#(
  parameter int EW = 7
) (
  input  logic [EW-1:0] est_sum,
  input  logic [EW-1:0] est_car,
  input  srt4_thr_t     thr,
  output logic          neg,
  output logic [1:0]    mag
);
  logic signed [EW-1:0] est;
  logic signed [7:0]    est8;
  logic ge1, ge2, le1, le2;

  // short carry-propagate add of the truncated words
  assign est  = signed'(est_sum + est_car);
  assign est8 = 8'(est);

  // sign path, independent of the comparators
  assign neg = est[EW-1];

  // comparisons against truncated divisor multiples
  assign ge1 = est8 >= thr.pos1;
  assign ge2 = est8 >= thr.pos2;
  assign le1 = est8 <= thr.neg1;
  assign le2 = est8 <= thr.neg2;

  // coder: comparator levels to magnitude
  always_comb begin
    if (neg) mag = {le2, le1 & ~le2};
    else     mag = {ge2, ge1 & ~ge2};
  end
endmodule

// File: rtl/srt4_csa.sv
module srt4_csa #(
  parameter int RW = 22
) (
  input  logic [RW-1:0] ws,
  input  logic [RW-1:0] wc,
  input  logic [RW-1:0] dvs,
  input  logic          neg,
  input  logic [1:0]    mag,
  output logic [RW-1:0] ns,
  output logic [RW-1:0] nc
);
  logic [RW-1:0] ys, yc, mult, addend;
  logic [RW-2:0] maj;
  logic          sub;

  assign ys = {ws[RW-3:0], 2'b00};
  assign yc = {wc[RW-3:0], 2'b00};

  always_comb begin
    unique case (mag)
      2'd1:    mult = dvs;
      2'd2:    mult = {dvs[RW-2:0], 1'b0};
      default: mult = '0;
    endcase
  end

  // positive digit: subtract the multiple (invert plus carry-in)
  assign sub    = !neg && (mag != 2'd0);
  assign addend = sub ? ~mult : mult;

  assign ns  = ys ^ yc ^ addend;
  assign maj = (ys[RW-2:0] & yc[RW-2:0]) | (ys[RW-2:0] & addend[RW-2:0]) |
               (yc[RW-2:0] & addend[RW-2:0]);
  assign nc  = {maj, sub};
endmodule

// File: rtl/srt4_otf.sv
module srt4_otf #(
  parameter int QW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          neg,
  input  logic [1:0]    mag,
  output logic [QW-1:0] q,
  output logic [QW-1:0] qm
);
  logic nz, dpos, dneg;
  assign nz   = mag != 2'd0;
  assign dpos = !neg && nz;
  assign dneg = neg && nz;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      q  <= '0;
      qm <= '1;
    end else if (step) begin
      q  <= dneg ? {qm[QW-3:0], 2'(~mag + 2'd1)} : {q[QW-3:0], mag};
      qm <= dpos ? {q[QW-3:0], 2'(mag - 2'd1)}  : {qm[QW-3:0], ~mag};
    end
  end
endmodule

// File: rtl/srt4_div.sv
module srt4_div
  import srt4_pkg::*;
#(
  parameter  int W     = 16,
  parameter  int QBITS = 16,
  localparam int ITERS = (QBITS + 3) / 2,
  localparam int QW    = 2 * ITERS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient,
  output logic [W-1:0]  remainder,
  output logic          sticky
);
  localparam int F  = W + 2;            // fraction bits of the remainder words
  localparam int RW = W + 6;            // remainder word width
  localparam int CW = $clog2(ITERS + 1);

  srt4_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] ws_q, wc_q, dvs_q, ns, nc;
  srt4_thr_t     thr_q;
  logic          dig_neg;
  logic [1:0]    dig_mag;
  logic [QW-1:0] q_acc, qm_acc;
  logic          accept, step;

  assign busy   = state_q != S_IDLE;
  assign accept = start && (state_q == S_IDLE);
  assign step   = state_q == S_RUN;

  srt4_qds #(.EW(7)) u_qds (
    .est_sum (ws_q[F:F-6]),
    .est_car (wc_q[F:F-6]),
    .thr     (thr_q),
    .neg     (dig_neg),
    .mag     (dig_mag)
  );

  srt4_csa #(.RW(RW)) u_csa (
    .ws  (ws_q),
    .wc  (wc_q),
    .dvs (dvs_q),
    .neg (dig_neg),
    .mag (dig_mag),
    .ns  (ns),
    .nc  (nc)
  );

  srt4_otf #(.QW(QW)) u_otf (
    .clk  (clk),
    .rst  (rst),
    .load (accept),
    .step (step),
    .neg  (dig_neg),
    .mag  (dig_mag),
    .q    (q_acc),
    .qm   (qm_acc)
  );

  // remainder assimilation and negative correction
  logic signed [RW-1:0] wfin, wcorr;
  assign wfin  = signed'(ws_q + wc_q);
  assign wcorr = wfin[RW-1] ? wfin + signed'(dvs_q) : wfin;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      ws_q      <= '0;
      wc_q      <= '0;
      dvs_q     <= '0;
      thr_q     <= '0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      sticky    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          ws_q    <= RW'(dividend);
          wc_q    <= '0;
          dvs_q   <= {4'b0000, divisor, 2'b00};
          thr_q   <= srt4_thresholds(divisor[W-2:W-4]);
          cnt_q   <= CW'(ITERS - 1);
          state_q <= S_RUN;
        end
        S_RUN: begin
          ws_q <= ns;
          wc_q <= nc;
          if (cnt_q == '0) state_q <= S_FIN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        S_FIN: begin
          quotient  <= wfin[RW-1] ? qm_acc : q_acc;
          remainder <= wcorr[W+1:2];
          sticky    <= |wcorr;
          done      <= 1'b1;
          state_q   <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // checks on the datapath and handshake
  logic signed [RW-1:0] wabs;
  assign wabs = wfin[RW-1] ? -wfin : wfin;

  AST_PR_CONTAINED: assert property (@(posedge clk) disable iff (rst)
    step |-> wabs <= signed'(dvs_q)) else $error("remainder escaped bound"); // R9
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy) else $error("start not taken"); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R3
  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    done |-> remainder < dvs_q[W+1:2]) else $error("remainder not below divisor"); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(dvs_q) && $stable(thr_q)) else $error("operand replaced"); // R7
endmodule

// File: tb/srt4_div_bench.sv
module srt4_div_bench;
  localparam int W     = 16;
  localparam int QBITS = 16;
  localparam int ITERS = (QBITS + 3) / 2;
  localparam int QW    = 2 * ITERS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  dividend = '0;
  logic [W-1:0]  divisor = '0;
  logic          busy, done, sticky;
  logic [QW-1:0] quotient;
  logic [W-1:0]  remainder;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  srt4_div #(.W(W), .QBITS(QBITS)) u_srt4_div (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .sticky(sticky)
  );

  // {dividend, divisor}
  localparam logic [31:0] STIM [0:11] = '{
    32'h8000_8000, 32'hFFFF_FFFF, 32'hFFFF_8000, 32'h8000_FFFF,
    32'h8001_8000, 32'h8000_8001, 32'hC000_8000, 32'hAAAA_C000,
    32'h9999_F0F0, 32'h8000_C000, 32'hFFFE_FFFF, 32'hB6DB_9249
  };

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    start = 1'b1; dividend = a; divisor = b;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, tag, longint'(busy), 1);
  endtask

  task automatic await_check(input logic [W-1:0] a, input logic [W-1:0] b, input int lat0);
    int lat = lat0;
    longint num, eq, er;
    num = longint'(a) << (2 * (ITERS - 1));
    eq  = num / longint'(b);
    er  = num % longint'(b);
    while (!done && lat < 64) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
    check(lat == ITERS + 1, "R3 latency", lat, ITERS + 1);
    check(busy == 1'b0, "R3 busy low with done", longint'(busy), 0);
    check(quotient == QW'(eq), "R4 R9 quotient", longint'(quotient), eq);
    check(remainder == W'(er), "R5 remainder", longint'(remainder), er);
    check(sticky == (er != 0), "R6 sticky", longint'(sticky), longint'(er != 0));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    report();
  end

  initial begin : main
    logic [31:0] rnd = 32'h1357_9BDF;
    logic [QW-1:0] held_q;
    logic [W-1:0]  held_r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0, "R1 flags", longint'({busy, done}), 0);
    check(quotient == '0 && remainder == '0 && sticky == 1'b0, "R1 data",
          longint'(quotient), 0);

    // table of vectors, issued back to back
    foreach (STIM[i]) begin
      launch(STIM[i][31:16], STIM[i][15:0], "R2 accept");
      await_check(STIM[i][31:16], STIM[i][15:0], 0);
    end

    // R10: result holds while idle and during the next run
    held_q = quotient; held_r = remainder;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(quotient == held_q && remainder == held_r && !done, "R10 hold idle",
            longint'(quotient), longint'(held_q));
    end
    launch(16'hE000, 16'h9000, "R2 accept");
    check(quotient == held_q, "R10 hold in run", longint'(quotient), longint'(held_q));
    await_check(16'hE000, 16'h9000, 0);

    // R7: stray start during the run with other operands
    @(negedge clk);
    launch(16'hF00D, 16'h8123, "R2 accept");
    @(posedge clk); @(negedge clk);
    start = 1'b1; dividend = 16'h8000; divisor = 16'hFFFF;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 still busy", longint'(busy), 1);
    await_check(16'hF00D, 16'h8123, 2);

    // R8: new start in the same cycle as done
    launch(16'h9ABC, 16'hDEF0, "R8 accepted on done");
    await_check(16'h9ABC, 16'hDEF0, 0);

    // random sweep, back to back
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] a, b;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      a = {1'b1, rnd[14:0]};
      b = {1'b1, rnd[30:16]};
      launch(a, b, "R2 accept");
      await_check(a, b, 0);
    end
    report();
  end
endmodule